// File: doc/BRIEF.md
# Variable-Width ADC Sample Unpacker

This block rebuilds the per-channel ADC readings of one front-end board from a densely packed readout stream. A board record is a run of 32-bit words. The first word is a selector with one bit per channel. Each bit chooses the code width for its channel: a 4-bit short code or a 12-bit long code. The payload words after it hold the codes back to back, so a code can begin in one word and end in the next.

The unpacker takes words on a valid/ready input. It keeps a small bit accumulator and a pointer to the next unread bit. It returns one channel per cycle as a channel index and a 12-bit value, and it marks the record's final channel. Short codes are signed and come out sign-extended to 12 bits. Long codes pass through unchanged. From the selector it works out how many payload words the record spans. It discards any fill bits left after the last code, so the next word is always read as a fresh selector.

Top module: `adc_unpack`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its state. At the next edge `in_ready` is 1 and `out_valid` is 0. The first word accepted after reset is taken as a selector word.
- R2: In a selector word, bit i set to 1 gives channel i a 12-bit long code, and bit i set to 0 gives channel i a 4-bit short code.
- R3: Codes are packed least-significant-bit first in rising channel order, continuing across word boundaries. Outputs appear in channel order 0 to 31, one per `out_valid` cycle.
- R4: A short code is output as its 4-bit two's-complement value sign-extended to 12 bits. A long code is output as-is.
- R5: A record's payload spans ceil((4·shorts + 12·longs)/32) words. Fill bits in the last payload word never reach the output. The first word accepted after that payload is the next record's selector.
- R6: `out_last` is 1 together with the output for channel 31 and is 0 for every other output. No output follows in the next cycle.
- R7: `in_ready` is 0 while 12 or more unread payload bits are held. It is also 0 once all payload words of the current record have been accepted and channels remain. The accumulator therefore never holds more than 43 bits.
- R8: Once enough unread bits are held for the current channel's code, that channel is output in the same cycle without waiting for more input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Selector or payload word |
| in_ready | output | 1 | Block accepts `in_data` this cycle |
| out_valid | output | 1 | A channel value is presented |
| out_chan | output | 5 | Channel index of the value |
| out_value | output | 12 | Decoded ADC value |
| out_last | output | 1 | Marks the record's final channel |

## Verification
The checker assumes each record is well formed: a selector word followed by exactly the number of payload words its bit count implies. Under that assumption the accumulator never runs dry before channel 31. The checker also assumes the output side is always able to take a value, because there is no output backpressure. The bench builds every record from its selector by arithmetic, fills the padding with random bits, and inserts random idle gaps on the input. It sweeps all one-hot selectors and a set of dense, sparse and random ones. It interrupts one record with a reset and discards the outputs from that interrupted record.

// File: rtl/adc_unpack_pkg.sv
// Package: shared types for the ADC unpacker.
// Assumes: nothing; holds only the record state encoding.
package adc_unpack_pkg;

    // Record phase: waiting for a selector word, or draining payload.
    typedef enum logic {
        PH_SELECT  = 1'b0,
        PH_PAYLOAD = 1'b1
    } rec_phase_t;

endpackage

// File: rtl/adc_word_count.sv
// adc_word_count: from a selector word, computes how many payload words
// the record occupies (ceiling of the total code bits over the word width).
// Assumes: one selector bit per channel, NUM_CH <= WORD_W.
module adc_word_count #(
    parameter int NUM_CH  = 32,
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 12,
    parameter int WL_W    = 4
) (
    input  logic [NUM_CH-1:0] sel_bits,
    output logic [WL_W-1:0]   word_cnt
);

    localparam int CNT_W = $clog2(NUM_CH + 1);

    logic [CNT_W-1:0] long_cnt;

    // Count channels that use the long code.
    always_comb begin
        long_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            long_cnt = long_cnt + CNT_W'(sel_bits[i]);
        end
    end

    // Convert the bit total into a whole number of words.
    always_comb begin
        int total_bits;
        total_bits = NUM_CH * SHORT_W + int'(long_cnt) * (LONG_W - SHORT_W);
        word_cnt   = WL_W'((total_bits + WORD_W - 1) / WORD_W);
    end

endmodule

// File: rtl/adc_bit_accum.sv
// adc_bit_accum: right-aligned bit accumulator. Consumed bits are shifted
// out at the bottom and new words are appended above the unread bits.
// Assumes: the caller never appends when fill - used + WORD_W > ACC_W.
module adc_bit_accum #(
    parameter int WORD_W = 32,
    parameter int LONG_W = 12,
    parameter int ACC_W  = 44,
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic [FILL_W-1:0] used,
    output logic [LONG_W-1:0] window,
    output logic [FILL_W-1:0] fill
);

    logic [ACC_W-1:0]  acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [ACC_W-1:0]  acc_d;
    logic [FILL_W-1:0] fill_d;
    logic [FILL_W-1:0] keep;

    // Next accumulator contents: drop the used bits, append any new word.
    always_comb begin
        keep   = fill_q - used;
        acc_d  = acc_q >> used;
        fill_d = keep;
        if (push) begin
            acc_d  = acc_d | ({{(ACC_W-WORD_W){1'b0}}, push_word} << keep);
            fill_d = keep + FILL_W'(WORD_W);
        end
    end

    // Register the accumulator; reset and record end discard everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else begin
            acc_q  <= acc_d;
            fill_q <= fill_d;
        end
    end

    assign window = acc_q[LONG_W-1:0];
    assign fill   = fill_q;

endmodule

// File: rtl/adc_sample_fmt.sv
// adc_sample_fmt: turns the low accumulator bits into an output value.
// A short code is sign-extended, a long code passes through.
// Assumes: window holds at least the selected code width of valid bits.
module adc_sample_fmt #(
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 12
) (
    input  logic [LONG_W-1:0] window,
    input  logic              is_long,
    output logic [LONG_W-1:0] value
);

    // Pick the width and extend the short code's sign bit.
    always_comb begin
        if (is_long) begin
            value = window;
        end else begin
            value = {{(LONG_W-SHORT_W){window[SHORT_W-1]}}, window[SHORT_W-1:0]};
        end
    end

endmodule

// File: rtl/adc_record_ctrl.sv
// adc_record_ctrl: sequences one record. It latches the selector word,
// walks the channels, counts the remaining payload words and decides when
// input is accepted and when a channel is output.
// Assumes: records are well formed (selector then the implied word count).
module adc_record_ctrl
    import adc_unpack_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 12,
    parameter int FILL_W  = 6,
    parameter int WL_W    = 4,
    parameter int CH_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [WL_W-1:0]   word_cnt,
    input  logic [FILL_W-1:0] fill,
    output logic              in_ready,
    output logic              push,
    output logic              emit,
    output logic              last,
    output logic              is_long,
    output logic [FILL_W-1:0] used,
    output logic [CH_W-1:0]   chan,
    output logic [NUM_CH-1:0] sel_q,
    output logic              payload_active
);

    localparam logic [FILL_W-1:0] SHORT_F = FILL_W'(SHORT_W);
    localparam logic [FILL_W-1:0] LONG_F  = FILL_W'(LONG_W);
    localparam logic [CH_W-1:0]   LAST_CH = CH_W'(NUM_CH - 1);

    rec_phase_t        phase_q;
    logic [CH_W-1:0]   chan_q;
    logic [WL_W-1:0]   words_left_q;
    logic [FILL_W-1:0] need;
    logic              sel_take;

    // Decode the current channel's code width and the handshake decisions.
    always_comb begin
        is_long  = sel_q[chan_q];
        need     = is_long ? LONG_F : SHORT_F;
        emit     = (phase_q == PH_PAYLOAD) && (fill >= need);
        last     = emit && (chan_q == LAST_CH);
        used     = emit ? need : '0;
        if (phase_q == PH_SELECT) begin
            in_ready = 1'b1;
        end else begin
            in_ready = (words_left_q != '0) && (fill < LONG_F);
        end
        sel_take = (phase_q == PH_SELECT) && in_valid;
        push     = (phase_q == PH_PAYLOAD) && in_valid && in_ready;
    end

    // Record state: selector capture, channel walk and word budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_SELECT;
            chan_q       <= '0;
            words_left_q <= '0;
            sel_q        <= '0;
        end else begin
            if (sel_take) begin
                sel_q        <= in_data[NUM_CH-1:0];
                chan_q       <= '0;
                words_left_q <= word_cnt;
                phase_q      <= PH_PAYLOAD;
            end else begin
                if (push) begin
                    words_left_q <= words_left_q - 1'b1;
                end
                if (emit) begin
                    chan_q <= chan_q + 1'b1;
                end
                if (last) begin
                    phase_q <= PH_SELECT;
                end
            end
        end
    end

    assign chan           = chan_q;
    assign payload_active = (phase_q == PH_PAYLOAD);

endmodule

// File: rtl/adc_unpack.sv
// adc_unpack: top of the variable-width ADC sample unpacker. Accepts a
// selector word then a packed payload, and outputs one channel per cycle.
// Assumes: the output side always accepts; records are well formed.
module adc_unpack #(
    parameter int NUM_CH  = 32,
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [$clog2(NUM_CH)-1:0] out_chan,
    output logic [LONG_W-1:0]         out_value,
    output logic                      out_last
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ACC_W  = WORD_W + LONG_W;
    localparam int FILL_W = $clog2(ACC_W + 1);
    localparam int MAX_WD = (NUM_CH * LONG_W + WORD_W - 1) / WORD_W;
    localparam int WL_W   = $clog2(MAX_WD + 1);

    logic [WL_W-1:0]   word_cnt;
    logic [FILL_W-1:0] fill_bits;
    logic [FILL_W-1:0] used_bits;
    logic [LONG_W-1:0] window;
    logic              push;
    logic              emit;
    logic              last;
    logic              is_long;
    logic [CH_W-1:0]   chan;
    logic [NUM_CH-1:0] sel_bits;
    logic              payload_active;

    adc_word_count #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W),
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W),
        .WL_W   (WL_W)
    ) u_wcount (
        .sel_bits(in_data[NUM_CH-1:0]),
        .word_cnt(word_cnt)
    );

    adc_record_ctrl #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W),
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W),
        .FILL_W (FILL_W),
        .WL_W   (WL_W),
        .CH_W   (CH_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .word_cnt      (word_cnt),
        .fill          (fill_bits),
        .in_ready      (in_ready),
        .push          (push),
        .emit          (emit),
        .last          (last),
        .is_long       (is_long),
        .used          (used_bits),
        .chan          (chan),
        .sel_q         (sel_bits),
        .payload_active(payload_active)
    );

    adc_bit_accum #(
        .WORD_W(WORD_W),
        .LONG_W(LONG_W),
        .ACC_W (ACC_W),
        .FILL_W(FILL_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (last),
        .push     (push),
        .push_word(in_data),
        .used     (used_bits),
        .window   (window),
        .fill     (fill_bits)
    );

    adc_sample_fmt #(
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W)
    ) u_fmt (
        .window (window),
        .is_long(is_long),
        .value  (out_value)
    );

    assign out_valid = emit;
    assign out_chan  = chan;
    assign out_last  = last;

endmodule

// File: rtl/adc_unpack_chk.sv
// adc_unpack_chk: temporal checks on the unpacker, bound into the top.
// Assumes: well-formed records and an always-ready output side.
module adc_unpack_chk #(
    parameter int NUM_CH  = 32,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 12,
    parameter int CH_W    = 5,
    parameter int FILL_W  = 6,
    parameter int ACC_W   = 44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_chan,
    input logic [LONG_W-1:0] out_value,
    input logic              out_last,
    input logic [FILL_W-1:0] fill_bits,
    input logic [NUM_CH-1:0] sel_bits,
    input logic              payload_active
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    // R3
    chan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_chan == $past(out_chan) + 1'b1));

    // R4
    short_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sel_bits[out_chan]) |->
            (out_value[LONG_W-1:SHORT_W] == {(LONG_W-SHORT_W){out_value[SHORT_W-1]}}));

    // R6
    last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_bits < FILL_W'(ACC_W));

    // R8
    prompt_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (payload_active && fill_bits >= FILL_W'(LONG_W)) |-> out_valid);

endmodule

bind adc_unpack adc_unpack_chk #(
    .NUM_CH (NUM_CH),
    .SHORT_W(SHORT_W),
    .LONG_W (LONG_W),
    .CH_W   (CH_W),
    .FILL_W (FILL_W),
    .ACC_W  (ACC_W)
) i_adc_unpack_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_chan      (out_chan),
    .out_value     (out_value),
    .out_last      (out_last),
    .fill_bits     (fill_bits),
    .sel_bits      (sel_bits),
    .payload_active(payload_active)
);

// File: tb/test_adc_unpack.sv
module test_adc_unpack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [4:0]  out_chan;
    logic [11:0] out_value;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int wr = 0;
    int rd = 0;
    bit ignore_out = 1'b0;

    logic [4:0]  exp_ch  [0:4095];
    logic [11:0] exp_val [0:4095];
    logic        exp_lst [0:4095];

    always #5 clk = ~clk;

    adc_unpack i_adc_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_chan (out_chan),
        .out_value(out_value),
        .out_last (out_last)
    );

    // Output monitor: compares each output against the expected list (R3 R4 R6).
    always @(negedge clk) begin
        if (rst_n && out_valid && !ignore_out) begin
            checks++;
            if (rd >= wr) begin
                fails++;
                $display("FAIL R5 unexpected output ch=%0d val=%h, expected none", out_chan, out_value);
            end else begin
                if (out_chan !== exp_ch[rd] || out_value !== exp_val[rd] || out_last !== exp_lst[rd]) begin
                    fails++;
                    $display("FAIL R3/R4/R6 out ch=%0d val=%h last=%b, expected ch=%0d val=%h last=%b",
                             out_chan, out_value, out_last, exp_ch[rd], exp_val[rd], exp_lst[rd]);
                end
                rd++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = $urandom;
    endtask

    // Build one record from its selector (R2 R5), queue expectations, drive it.
    task automatic do_record(input logic [31:0] sel, input int seed, input int gap, input bit chk_bp);
        logic [511:0] pay;
        int pos;
        int nwords;
        pay = '0;
        for (int k = 0; k < 16; k++) pay[k*32 +: 32] = $urandom;
        pos = 0;
        for (int ch = 0; ch < 32; ch++) begin
            if (sel[ch]) begin
                int v;
                v = (seed * 1237 + ch * 291 + 2048) % 4096;
                pay[pos +: 12] = 12'(v);
                exp_val[wr] = 12'(v);
                pos += 12;
            end else begin
                int v;
                v = (seed * 7 + ch * 3) % 16;
                pay[pos +: 4] = 4'(v);
                exp_val[wr] = (v >= 8) ? 12'(v + 4080) : 12'(v);
                pos += 4;
            end
            exp_ch[wr]  = 5'(ch);
            exp_lst[wr] = (ch == 31);
            wr++;
        end
        for (int p = pos; p < 512; p++) pay[p] = pay[p];
        nwords = (pos + 31) / 32;
        send(sel);
        for (int k = 0; k < nwords; k++) begin
            send(pay[k*32 +: 32]);
            if (chk_bp && k == 0) begin
                // R7: 32 unread bits are held, so no input is taken
                check("R7 ready low with >=12 bits held", {31'b0, in_ready}, 32'h0);
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (rd < wr && t < 200) begin
            @(negedge clk);
            t++;
        end
        check("R5 all channels of the record output", rd, wr);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired rd=%0d expected=%0d", rd, wr);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ready after reset", {31'b0, in_ready}, 32'h1);
        check("R1 no output in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'b0, out_valid}, 32'h0);

        // R2 R4: all short, all long, alternating patterns
        do_record(32'h0000_0000, 1, 0, 1'b0);
        do_record(32'hFFFF_FFFF, 2, 0, 1'b1);
        do_record(32'h5555_5555, 3, 1, 1'b0);
        do_record(32'hAAAA_AAAA, 4, 0, 1'b0);
        do_record(32'hF0F0_0F0F, 5, 2, 1'b0);
        drain();

        // R3 R5: every one-hot selector shifts the long code's position
        for (int b = 0; b < 32; b++) do_record(32'h1 << b, 10 + b, b % 3, 1'b0);
        drain();

        // R5 R8: random selectors with random idle gaps, short codes cycling all 16 values
        for (int r = 0; r < 20; r++) do_record($urandom, 50 + r, $urandom % 3, 1'b0);
        drain();

        // R1: reset in the middle of a record discards it
        ignore_out = 1'b1;
        send(32'h0000_00FF);
        send(32'h1234_5678);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ignore_out = 1'b0;
        check("R1 ready during reset after partial record", {31'b0, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 no stale output after reset", {31'b0, out_valid}, 32'h0);
        do_record(32'h8000_0001, 99, 0, 1'b0);
        drain();

        @(negedge clk);
        check("R6 no output after last channel", {31'b0, out_valid}, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule